// File: doc/BRIEF.md
# Dual-Clock Block RAM with Selectable Shape

This block is a simple dual-port memory: one write port and one read port, each on its own clock. One storage block holds 4.5 kilobits, organised as two 9-bit lanes of 256 rows. A shape parameter fixes how the ports see that storage. A single block is seen either as 256 words of 18 bits or as 512 words of 9 bits. Two blocks can be paired with no extra glue logic. Stacked, they give 512 words of 18 bits, or 1024 words of 9 bits when each block is narrow. Side by side, they give 256 words of 36 bits.

Each port has its own select. A write commits only the 9-bit lanes whose enable bit is set. The read port captures the addressed word into an output register. A second parameter adds one more register stage behind it. The user must keep a write and a read on the same address apart, because the data returned by such a collision is undefined.

Top module: `dpr_ram`

## Requirements
- R1: While rd_rst_n is low, rd_data is all zeros. It stays zero after release until the first read.
- R2: A lane is written only at a rising wr_clk edge where wr_sel and that lane's bit of wr_lane_en are both high. Lane k is wr_data[9k+8:9k]. All other lanes of the word keep their contents.
- R3: At a rising wr_clk edge where wr_sel is low, no location changes, whatever wr_lane_en holds.
- R4: With PIPE_RD = 0, rd_data shows the word at rd_addr after the first rising rd_clk edge where rd_sel is high.
- R5: With PIPE_RD = 1, that word appears one rd_clk edge later. The second stage loads on every edge.
- R6: At an edge where rd_sel is low, the first read register holds its value. With PIPE_RD = 0, rd_data does not change. With PIPE_RD = 1, rd_data does not change after two such edges in a row.
- R7: SHAPE_256X18 uses an 8-bit address, 18-bit data and 2 lane enables. SHAPE_512X9 uses a 9-bit address, 9-bit data and 1 enable.
- R8: SHAPE_512X18 pairs two blocks vertically. wr_addr[8] picks the block that takes a write. The registered rd_addr[8] picks the block whose output reaches rd_data. No write reaches both blocks.
- R9: SHAPE_256X36 pairs two blocks horizontally. It uses an 8-bit address, 36-bit data and 4 lane enables.
- R10: SHAPE_1024X9 pairs two narrow blocks vertically. It uses a 10-bit address, 9-bit data and 1 enable, and the address's top bit picks the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| wr_sel | input | 1 | Write port select |
| wr_lane_en | input | DW/9 | Per-lane write enables |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | Write data |
| rd_clk | input | 1 | Read clock, independent of wr_clk |
| rd_rst_n | input | 1 | Active-low asynchronous clear of the read registers |
| rd_sel | input | 1 | Read port select |
| rd_addr | input | AW | Read word address |
| rd_data | output | DW | Read data |

## Verification
A write commits at the rising edge where it is presented. A read is due half a period after the rising edge that samples rd_sel when PIPE_RD is 0, and half a period after the following edge when PIPE_RD is 1. The bench drives inputs on falling edges. Its model advances the first stage and the pipeline stage once per rising edge, using the contents before that edge's write, and it compares on the next falling edge. Five instances, one for each shape and with both pipeline settings, see the same stimulus. Reads never share their low address bits with a write in the same cycle.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [2:0] {
        SHAPE_256X18,
        SHAPE_512X9,
        SHAPE_512X18,
        SHAPE_256X36,
        SHAPE_1024X9
    } shape_e;

    // address width seen at the ports
    function automatic int shape_aw(shape_e s, int row_aw);
        case (s)
            SHAPE_256X18: return row_aw;
            SHAPE_256X36: return row_aw;
            SHAPE_1024X9: return row_aw + 2;
            default:      return row_aw + 1;
        endcase
    endfunction

    // data width seen at the ports
    function automatic int shape_dw(shape_e s, int lane_w);
        case (s)
            SHAPE_512X9:  return lane_w;
            SHAPE_1024X9: return lane_w;
            SHAPE_256X36: return 4 * lane_w;
            default:      return 2 * lane_w;
        endcase
    endfunction

    function automatic int shape_nblk(shape_e s);
        return (s == SHAPE_256X18 || s == SHAPE_512X9) ? 1 : 2;
    endfunction

    function automatic bit shape_narrow(shape_e s);
        return (s == SHAPE_512X9 || s == SHAPE_1024X9);
    endfunction

    function automatic bit shape_vert(shape_e s);
        return (s == SHAPE_512X18 || s == SHAPE_1024X9);
    endfunction

    function automatic bit shape_horiz(shape_e s);
        return (s == SHAPE_256X36);
    endfunction

endpackage

// File: rtl/dpr_lane.sv
module dpr_lane #(
    parameter int LANE_W = 9,
    parameter int ROW_AW = 8
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ROW_AW-1:0] wr_row,
    input  logic [LANE_W-1:0] wr_din,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [ROW_AW-1:0] rd_row,
    output logic [LANE_W-1:0] rd_dout
);
    localparam int ROWS = 1 << ROW_AW;

    logic [LANE_W-1:0] mem_q [ROWS];
    logic [LANE_W-1:0] dout_d;
    logic [LANE_W-1:0] dout_q;

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem_q[wr_row] <= wr_din;
        end
    end

    always_comb begin
        dout_d = dout_q;
        if (rd_en) begin
            dout_d = mem_q[rd_row];
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            dout_q <= '0;
        end else begin
            dout_q <= dout_d;
        end
    end

    assign rd_dout = dout_q;

endmodule

// File: rtl/dpr_block.sv
module dpr_block #(
    parameter int LANE_W = 9,
    parameter int ROW_AW = 8,
    parameter bit NARROW = 1'b0
) (
    input  logic                wr_clk,
    input  logic                wr_sel,
    input  logic [1:0]          wr_en,
    input  logic [ROW_AW:0]     wr_addr,
    input  logic [2*LANE_W-1:0] wr_data,
    input  logic                rd_clk,
    input  logic                rd_rst_n,
    input  logic                rd_sel,
    input  logic [ROW_AW:0]     rd_addr,
    output logic [2*LANE_W-1:0] rd_data,
    output logic [1:0]          lane_strobe
);
    localparam int BW = 2 * LANE_W;

    typedef struct packed {
        logic half;
    } blk_rd_t;

    blk_rd_t           rd_d;
    blk_rd_t           rd_q;
    logic [LANE_W-1:0] lane_din [2];
    logic [LANE_W-1:0] lane_out [2];

    // write side: narrow mode steers one lane by the extra address bit
    always_comb begin
        for (int k = 0; k < 2; k++) begin
            if (NARROW) begin
                lane_strobe[k] = wr_sel && wr_en[0] && (wr_addr[ROW_AW] == 1'(k));
                lane_din[k]    = wr_data[LANE_W-1:0];
            end else begin
                lane_strobe[k] = wr_sel && wr_en[k];
                lane_din[k]    = wr_data[k*LANE_W +: LANE_W];
            end
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_lane
        dpr_lane #(
            .LANE_W (LANE_W),
            .ROW_AW (ROW_AW)
        ) u_lane (
            .wr_clk   (wr_clk),
            .wr_en    (lane_strobe[k]),
            .wr_row   (wr_addr[ROW_AW-1:0]),
            .wr_din   (lane_din[k]),
            .rd_clk   (rd_clk),
            .rd_rst_n (rd_rst_n),
            .rd_en    (rd_sel),
            .rd_row   (rd_addr[ROW_AW-1:0]),
            .rd_dout  (lane_out[k])
        );
    end

    // read side: remember which half was addressed
    always_comb begin
        rd_d = rd_q;
        if (rd_sel) begin
            rd_d.half = NARROW ? rd_addr[ROW_AW] : 1'b0;
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_comb begin
        if (NARROW) begin
            rd_data = BW'(rd_q.half ? lane_out[1] : lane_out[0]);
        end else begin
            rd_data = {lane_out[1], lane_out[0]};
        end
    end

endmodule

// File: rtl/dpr_ram.sv
module dpr_ram
    import dpr_pkg::*;
#(
    parameter shape_e SHAPE   = SHAPE_256X18,
    parameter bit     PIPE_RD = 1'b0,
    parameter int     LANE_W  = 9,
    parameter int     ROW_AW  = 8,
    localparam int    AW      = shape_aw(SHAPE, ROW_AW),
    localparam int    DW      = shape_dw(SHAPE, LANE_W),
    localparam int    EW      = DW / LANE_W
) (
    input  logic          wr_clk,
    input  logic          wr_sel,
    input  logic [EW-1:0] wr_lane_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_sel,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int  NBLK   = shape_nblk(SHAPE);
    localparam bit  NARROW = shape_narrow(SHAPE);
    localparam bit  VERT   = shape_vert(SHAPE);
    localparam bit  HORIZ  = shape_horiz(SHAPE);
    localparam int  BW     = 2 * LANE_W;
    localparam int  BAW    = ROW_AW + 1;
    localparam int  PAW    = ROW_AW + 2;

    typedef struct packed {
        logic          blk;
        logic [DW-1:0] pipe;
    } top_rd_t;

    logic [PAW-1:0]      wpad;
    logic [PAW-1:0]      rpad;
    logic [3:0]          epad;
    logic [4*LANE_W-1:0] dpad;

    logic                blk_wsel  [NBLK];
    logic [1:0]          blk_wen   [NBLK];
    logic [BW-1:0]       blk_wdata [NBLK];
    logic [BW-1:0]       blk_rd    [NBLK];
    logic [2*NBLK-1:0]   lane_strobe;

    top_rd_t             rd_d;
    top_rd_t             rd_q;
    logic [DW-1:0]       stage1;

    assign wpad = PAW'(wr_addr);
    assign rpad = PAW'(rd_addr);
    assign epad = 4'(wr_lane_en);
    assign dpad = (4*LANE_W)'(wr_data);

    // block decode
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        if (HORIZ) begin : g_h
            always_comb begin
                blk_wsel[b]  = wr_sel;
                blk_wen[b]   = epad[2*b +: 2];
                blk_wdata[b] = dpad[b*BW +: BW];
            end
        end else if (VERT) begin : g_v
            always_comb begin
                blk_wsel[b]  = wr_sel && (wpad[AW-1] == 1'(b));
                blk_wen[b]   = epad[1:0];
                blk_wdata[b] = dpad[BW-1:0];
            end
        end else begin : g_s
            always_comb begin
                blk_wsel[b]  = wr_sel;
                blk_wen[b]   = epad[1:0];
                blk_wdata[b] = dpad[BW-1:0];
            end
        end

        dpr_block #(
            .LANE_W (LANE_W),
            .ROW_AW (ROW_AW),
            .NARROW (NARROW)
        ) u_blk (
            .wr_clk      (wr_clk),
            .wr_sel      (blk_wsel[b]),
            .wr_en       (blk_wen[b]),
            .wr_addr     (wpad[BAW-1:0]),
            .wr_data     (blk_wdata[b]),
            .rd_clk      (rd_clk),
            .rd_rst_n    (rd_rst_n),
            .rd_sel      (rd_sel),
            .rd_addr     (rpad[BAW-1:0]),
            .rd_data     (blk_rd[b]),
            .lane_strobe (lane_strobe[2*b +: 2])
        );
    end

    // output assembly from the first read stage
    if (HORIZ) begin : g_out_h
        assign stage1 = DW'({blk_rd[1], blk_rd[0]});
    end else if (VERT) begin : g_out_v
        assign stage1 = DW'(rd_q.blk ? blk_rd[1] : blk_rd[0]);
    end else begin : g_out_s
        assign stage1 = DW'(blk_rd[0]);
    end

    always_comb begin
        rd_d      = rd_q;
        rd_d.pipe = stage1;
        if (rd_sel && VERT) begin
            rd_d.blk = rpad[AW-1];
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = PIPE_RD ? rd_q.pipe : stage1;

endmodule

// File: rtl/dpr_ram_chk.sv
module dpr_ram_chk #(
    parameter int EW      = 2,
    parameter int NBLK    = 1,
    parameter int DW      = 18,
    parameter bit PIPE_RD = 1'b0,
    parameter bit VERT    = 1'b0
) (
    input logic              wr_clk,
    input logic              wr_sel,
    input logic [EW-1:0]     wr_lane_en,
    input logic [2*NBLK-1:0] lane_strobe,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_sel,
    input logic [DW-1:0]     rd_data
);
    always @(negedge rd_clk) begin
        if (!rd_rst_n) begin
            assert_reset_zero_R1: assert (rd_data == '0)
                else $error("read data not cleared in reset");
        end
    end

    always @(posedge wr_clk) begin
        if (!$isunknown(lane_strobe) && (|lane_strobe)) begin
            assert_sel_gate_R3: assert (wr_sel)
                else $error("lane written without write select");
            assert_lane_en_R2: assert (|wr_lane_en)
                else $error("lane written with no lane enable");
        end
    end

    if (VERT) begin : g_vert
        always @(posedge wr_clk) begin
            if (!$isunknown(lane_strobe)) begin
                assert_one_block_R8: assert ($onehot0({|lane_strobe[3:2], |lane_strobe[1:0]}))
                    else $error("write reached both paired blocks");
            end
        end
    end

    if (PIPE_RD) begin : g_pipe
        assert_hold_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
            (!rd_sel && $past(!rd_sel)) |=> $stable(rd_data))
            else $error("pipelined read data moved while idle");
    end else begin : g_flat
        assert_hold_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
            !rd_sel |=> $stable(rd_data))
            else $error("read data moved while idle");
    end

endmodule

bind dpr_ram dpr_ram_chk #(
    .EW      (EW),
    .NBLK    (NBLK),
    .DW      (DW),
    .PIPE_RD (PIPE_RD),
    .VERT    (VERT)
) u_chk (
    .wr_clk      (wr_clk),
    .wr_sel      (wr_sel),
    .wr_lane_en  (wr_lane_en),
    .lane_strobe (lane_strobe),
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data)
);

// File: tb/dpr_ram_tb_top.sv
module dpr_ram_tb_top;
    import dpr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ws = 1'b0;
    logic [3:0]  we = '0;
    logic [9:0]  wa = '0;
    logic [35:0] wd = '0;
    logic        rs = 1'b0;
    logic [9:0]  ra = '0;

    logic [17:0] q0;
    logic [8:0]  q1;
    logic [17:0] q2;
    logic [35:0] q3;
    logic [8:0]  q4;
    logic [35:0] got [5];

    int n_chk  = 0;
    int n_fail = 0;

    int          aw_k [5] = '{8, 9, 9, 8, 10};
    int          nl_k [5] = '{2, 1, 2, 4, 1};
    bit          pp_k [5] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    string       nm_k [5] = '{"R7 256x18", "R7 512x9", "R8 R5 512x18", "R9 256x36", "R10 R5 1024x9"};
    logic [35:0] mdl  [5][1024];
    logic [35:0] st1  [5];
    logic [35:0] st2  [5];

    always #5 clk = ~clk;

    dpr_ram #(.SHAPE(SHAPE_256X18), .PIPE_RD(1'b0)) dut_i (
        .wr_clk(clk), .wr_sel(ws), .wr_lane_en(we[1:0]), .wr_addr(wa[7:0]), .wr_data(wd[17:0]),
        .rd_clk(clk), .rd_rst_n(rst_n), .rd_sel(rs), .rd_addr(ra[7:0]), .rd_data(q0));
    dpr_ram #(.SHAPE(SHAPE_512X9), .PIPE_RD(1'b0)) dut_n_i (
        .wr_clk(clk), .wr_sel(ws), .wr_lane_en(we[0:0]), .wr_addr(wa[8:0]), .wr_data(wd[8:0]),
        .rd_clk(clk), .rd_rst_n(rst_n), .rd_sel(rs), .rd_addr(ra[8:0]), .rd_data(q1));
    dpr_ram #(.SHAPE(SHAPE_512X18), .PIPE_RD(1'b1)) dut_v_i (
        .wr_clk(clk), .wr_sel(ws), .wr_lane_en(we[1:0]), .wr_addr(wa[8:0]), .wr_data(wd[17:0]),
        .rd_clk(clk), .rd_rst_n(rst_n), .rd_sel(rs), .rd_addr(ra[8:0]), .rd_data(q2));
    dpr_ram #(.SHAPE(SHAPE_256X36), .PIPE_RD(1'b0)) dut_h_i (
        .wr_clk(clk), .wr_sel(ws), .wr_lane_en(we), .wr_addr(wa[7:0]), .wr_data(wd),
        .rd_clk(clk), .rd_rst_n(rst_n), .rd_sel(rs), .rd_addr(ra[7:0]), .rd_data(q3));
    dpr_ram #(.SHAPE(SHAPE_1024X9), .PIPE_RD(1'b1)) dut_d_i (
        .wr_clk(clk), .wr_sel(ws), .wr_lane_en(we[0:0]), .wr_addr(wa), .wr_data(wd[8:0]),
        .rd_clk(clk), .rd_rst_n(rst_n), .rd_sel(rs), .rd_addr(ra), .rd_data(q4));

    assign got[0] = 36'(q0);
    assign got[1] = 36'(q1);
    assign got[2] = 36'(q2);
    assign got[3] = 36'(q3);
    assign got[4] = 36'(q4);

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] fill_word(input int i);
        logic [31:0] h = 32'(i) * 32'h9E37_79B1;
        return {4'(i), h ^ 32'h5A5A_0F0F};
    endfunction

    // one rising edge with the given inputs; all five outputs are checked half a period later
    task automatic cyc(input bit ws_i, input logic [3:0] we_i, input logic [9:0] wa_i,
                       input logic [35:0] wd_i, input bit rs_i, input logic [9:0] ra_i,
                       input string tag);
        ws = ws_i; we = we_i; wa = wa_i; wd = wd_i; rs = rs_i; ra = ra_i;
        @(posedge clk);
        for (int k = 0; k < 5; k++) begin
            int m  = (1 << aw_k[k]) - 1;
            int ar = int'(ra_i) & m;
            int aw = int'(wa_i) & m;
            st2[k] = st1[k];
            if (rs_i) st1[k] = mdl[k][ar];
            if (ws_i) begin
                for (int l = 0; l < nl_k[k]; l++) begin
                    if (we_i[l]) mdl[k][aw][9*l +: 9] = wd_i[9*l +: 9];
                end
            end
        end
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            check($sformatf("%s [%s]", tag, nm_k[k]), got[k], pp_k[k] ? st2[k] : st1[k]);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'h0, 10'h0, 36'h0, 1'b0, 10'h0, tag);
    endtask

    task automatic rd(input logic [9:0] a, input string tag);
        cyc(1'b0, 4'h0, 10'h0, 36'h0, 1'b1, a, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R4 watchdog: got hung run expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int k = 0; k < 5; k++) begin
            st1[k] = '0;
            st2[k] = '0;
            for (int a = 0; a < 1024; a++) mdl[k][a] = '0;
        end

        // R1: reset clears the read registers
        repeat (3) @(negedge clk);
        for (int k = 0; k < 5; k++) check($sformatf("R1 in reset [%s]", nm_k[k]), got[k], 36'h0);
        rst_n = 1'b1;
        idle(2, "R1 after release");

        // fill every location; reads stay off so outputs hold (R6)
        for (int i = 0; i < 1024; i++) begin
            cyc(1'b1, 4'hF, 10'(i), fill_word(i), 1'b0, 10'h0, "R6 fill");
        end

        // plain reads, latency per R4 and R5
        rd(10'h005, "R4 R5 read");
        rd(10'h106, "R4 R5 read");
        rd(10'h3FF, "R4 R5 read");
        idle(2, "R5 drain");

        // R2: partial lane writes
        cyc(1'b1, 4'b0101, 10'h005, 36'hF_FFFF_FFFF, 1'b0, 10'h0, "R2 write");
        cyc(1'b1, 4'b1010, 10'h106, 36'h0_0000_0000, 1'b0, 10'h0, "R2 write");
        rd(10'h005, "R2 read");
        rd(10'h106, "R2 read");
        rd(10'h006, "R8 R10 other block");
        idle(2, "R2 drain");

        // R3: write with select low changes nothing
        cyc(1'b0, 4'hF, 10'h007, 36'h1_2345_6789, 1'b0, 10'h0, "R3 write");
        cyc(1'b0, 4'hF, 10'h207, 36'hA_BCDE_F012, 1'b0, 10'h0, "R3 write");
        rd(10'h007, "R3 read");
        rd(10'h207, "R3 read");
        idle(2, "R3 drain");

        // R8/R10: top address bit picks the block
        cyc(1'b1, 4'hF, 10'h003, 36'h1_1111_1111, 1'b0, 10'h0, "R8 write");
        cyc(1'b1, 4'hF, 10'h103, 36'h2_2222_2222, 1'b0, 10'h0, "R8 write");
        cyc(1'b1, 4'hF, 10'h303, 36'h3_3333_3333, 1'b0, 10'h0, "R10 write");
        rd(10'h003, "R8 R10 read");
        rd(10'h103, "R8 R10 read");
        rd(10'h203, "R8 R10 read");
        rd(10'h303, "R8 R10 read");
        idle(2, "R8 drain");

        // R6: output holds while the read select is low and the address moves
        rd(10'h0AA, "R6 setup");
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 4'h0, 10'h0, 36'h0, 1'b0, 10'($urandom), "R6 hold");
        end

        // mixed random traffic; low read address bits never match the write
        for (int i = 0; i < 4000; i++) begin
            logic [9:0]  a_w = 10'($urandom);
            logic [9:0]  a_r = 10'($urandom);
            logic [35:0] d   = {4'($urandom), 32'($urandom)};
            bit          w   = ($urandom % 3) != 0;
            bit          r   = ($urandom % 4) != 0;
            if (a_r[7:0] == a_w[7:0]) a_r[0] = ~a_r[0];
            cyc(w, 4'($urandom), a_w, d, r, a_r, "R2 R4 R5 R6 random");
        end
        idle(2, "R5 final drain");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule